// File: doc/BRIEF.md
# Counter-Driven CORDIC Twiddle Rotator

This block multiplies a stream of complex samples by the twiddle factor of a two-dimensional transform decomposition, with no twiddle table. Each accepted sample gets a running position inside the current transform frame. The low bits of that position give the column index k and the high bits give the row index n. The product n·k, reduced modulo the transform length N, becomes a phase word through a size-dependent left shift. A pipelined CORDIC in rotation mode then turns the input vector clockwise by 2π·(n·k mod N)/N.

The angle first passes through a quarter-turn reduction. Then 17 unrolled microrotations run on a datapath that carries five guard bits beyond the 16-bit sample width. A fixed multiply by the inverse CORDIC gain follows, and the result is rounded and saturated back to 16 bits. The transform length is chosen per frame: 2048, 4096 or 8192 points. A frame-start flag aligns the position counter with the data stream. The pipeline takes one sample per cycle and has no stalls.

Top module: `twiddle_rotator`

## Requirements
- R1: For each accepted sample at position p, with k = p[4:0] and n = p >> 5, out = in · e^(−j·2π·((n·k) mod N)/N), where in = in_re + j·in_im. Each output component lies within 4 LSB of the exactly rounded value.
- R2: After reset, positions start at 0 and rise by one for each accepted sample. After position N−1 the next accepted sample takes position 0, without any frame-start flag.
- R3: A sample accepted with in_sof high takes position 0, whatever the counter held. The following samples continue from position 1.
- R4: size_sel selects N: code 0 gives 2048, code 1 gives 4096, codes 2 and 3 give 8192.
- R5: A result is presented with out_valid high exactly 21 cycles after its sample is accepted, and results come out in input order. Cycles with in_valid low produce no output and do not advance the position.
- R6: A result whose magnitude exceeds the 16-bit signed range is clamped to 32767 or −32768, keeping its sign.
- R7: While rst_n is low, out_valid, out_re and out_im read zero on the following cycle.
- R8: Rotations by angles in every quadrant are correct, including angles beyond a quarter turn in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample accepted this cycle |
| in_sof | input | 1 | Accepted sample is the first of a frame (position 0) |
| size_sel | input | 2 | Transform length code (0: 2048, 1: 4096, 2 and 3: 8192) |
| in_re | input | 16 | Real part of the input sample, signed |
| in_im | input | 16 | Imaginary part of the input sample, signed |
| out_valid | output | 1 | Rotated sample present |
| out_re | output | 16 | Real part of the rotated sample, signed |
| out_im | output | 16 | Imaginary part of the rotated sample, signed |

## Verification
Every result is due exactly 21 cycles after its sample is accepted. The cycles are one for position and angle formation, one for quadrant reduction, 17 for the microrotations, one for the gain product and one for the rounded, saturated output register. The bench logs the cycle on which each sample is driven, together with its expected value. That expected value comes from a position counter kept in the bench and from real-valued sine and cosine. An output monitor sampling on the falling edge pops these entries in order and checks both components and the 21-cycle distance. Any output with no pending entry, or any entry left over after the drain, counts as a failure.

// File: rtl/twr_pkg.sv
`timescale 1ns/1ps
package twr_pkg;
   localparam real TWO_PI = 6.283185307179586;

   // size code -> log2 of transform length
   typedef enum logic [1:0] {
      SZ_SMALL = 2'd0,
      SZ_MID   = 2'd1,
      SZ_LARGE = 2'd2,
      SZ_ALIAS = 2'd3
   } twr_size_e;

   function automatic int logn_of(input logic [1:0] code, input int log_min);
      case (twr_size_e'(code))
         SZ_SMALL: return log_min;
         SZ_MID:   return log_min + 1;
         default:  return log_min + 2;
      endcase
   endfunction

   // elementary angle atan(2^-i) in units of (full turn / 2^zw)
   function automatic int atan_code(input int i, input int zw);
      real r;
      r = $atan(2.0 ** (-i)) / TWO_PI * (2.0 ** zw);
      return $rtoi(r + 0.5);
   endfunction

   // inverse of the accumulated CORDIC gain, scaled by 2^kf
   function automatic int gain_code(input int iter, input int kf);
      real g;
      g = 1.0;
      for (int i = 0; i < iter; i++) g = g / $sqrt(1.0 + 2.0 ** (-2 * i));
      return $rtoi(g * (2.0 ** kf) + 0.5);
   endfunction
endpackage

// File: rtl/twr_index_gen.sv
`timescale 1ns/1ps
module twr_index_gen #(
   parameter int DW      = 16,
   parameter int LOG_MIN = 11,
   parameter int COLW    = 5,
   parameter int ZW      = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic [1:0]           size_sel,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 o_valid,
   output logic signed [DW-1:0] o_re,
   output logic signed [DW-1:0] o_im,
   output logic [ZW-1:0]        o_ang
);
   localparam int CNTW = LOG_MIN + 2;
   localparam int ROWW = CNTW - COLW;

   logic [CNTW-1:0] cnt_q, idx, last_idx, prod;
   logic [ROWW-1:0] row;
   logic [COLW-1:0] col;
   logic [ZW-1:0]   ang;
   int              logn;

   always_comb begin
      logn     = twr_pkg::logn_of(size_sel, LOG_MIN);
      last_idx = {CNTW{1'b1}} >> (CNTW - logn);
      idx      = in_sof ? '0 : cnt_q;
      row      = idx[CNTW-1:COLW];
      col      = idx[COLW-1:0];
      prod     = {{COLW{1'b0}}, row} * {{ROWW{1'b0}}, col};
      // shifting the product to the top of the phase word drops multiples of N
      ang      = ZW'(prod) << (ZW - logn);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         o_valid <= 1'b0;
      end else begin
         o_valid <= in_valid;
         if (in_valid) cnt_q <= (idx >= last_idx) ? '0 : idx + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         o_re  <= in_re;
         o_im  <= in_im;
         o_ang <= ang;
      end
   end

   // R3: a frame-start sample carries position 0, hence a zero phase
   assert_sof_zero_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (o_valid && o_ang == '0));
endmodule

// File: rtl/twr_prerot.sv
`timescale 1ns/1ps
module twr_prerot #(
   parameter int DW    = 16,
   parameter int GUARD = 5,
   parameter int W     = 23,
   parameter int ZW    = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_valid,
   input  logic signed [DW-1:0] i_re,
   input  logic signed [DW-1:0] i_im,
   input  logic [ZW-1:0]        i_ang,
   output logic                 o_valid,
   output logic signed [W-1:0]  o_x,
   output logic signed [W-1:0]  o_y,
   output logic signed [ZW-1:0] o_z
);
   localparam logic signed [ZW-1:0] QTR = ZW'(1) << (ZW - 2);

   logic signed [W-1:0]  xe, ye, xn, yn;
   logic signed [ZW-1:0] z0, zn;

   always_comb begin
      xe = W'(i_re) <<< GUARD;
      ye = W'(i_im) <<< GUARD;
      z0 = -$signed(i_ang);              // clockwise twiddle
      case (z0[ZW-1:ZW-2])
         2'b01: begin xn = -ye; yn = xe;  zn = z0 - QTR; end  // +quarter turn
         2'b10: begin xn = ye;  yn = -xe; zn = z0 + QTR; end  // -quarter turn
         default: begin xn = xe; yn = ye; zn = z0; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) o_valid <= 1'b0;
      else        o_valid <= i_valid;
   end

   always_ff @(posedge clk) begin
      o_x <= xn;
      o_y <= yn;
      o_z <= zn;
   end

   // R8: the residual angle handed to the microrotations lies within a quarter turn
   assert_reduced_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (o_z[ZW-1] == o_z[ZW-2]));
endmodule

// File: rtl/twr_micro_stage.sv
`timescale 1ns/1ps
module twr_micro_stage #(
   parameter int W    = 23,
   parameter int ZW   = 22,
   parameter int IDX  = 0,
   parameter int ATAN = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_valid,
   input  logic signed [W-1:0]  i_x,
   input  logic signed [W-1:0]  i_y,
   input  logic signed [ZW-1:0] i_z,
   output logic                 o_valid,
   output logic signed [W-1:0]  o_x,
   output logic signed [W-1:0]  o_y,
   output logic signed [ZW-1:0] o_z
);
   localparam logic signed [ZW-1:0] AC    = ZW'(ATAN);
   localparam logic [ZW-1:0]        BOUND = ZW'(ATAN + 32);

   logic                dir_pos;
   logic signed [W-1:0] xs, ys;
   logic [ZW-1:0]       mag;

   always_comb begin
      dir_pos = !i_z[ZW-1];
      xs      = i_x >>> IDX;
      ys      = i_y >>> IDX;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) o_valid <= 1'b0;
      else        o_valid <= i_valid;
   end

   always_ff @(posedge clk) begin
      if (dir_pos) begin
         o_x <= i_x - ys;
         o_y <= i_y + xs;
         o_z <= i_z - AC;
      end else begin
         o_x <= i_x + ys;
         o_y <= i_y - xs;
         o_z <= i_z + AC;
      end
   end

   assign mag = o_z[ZW-1] ? ZW'(-o_z) : ZW'(o_z);

   // R1: residual angle converges, never exceeding this stage's elementary angle
   assert_residual_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (mag <= BOUND));
endmodule

// File: rtl/twr_gain.sv
`timescale 1ns/1ps
module twr_gain #(
   parameter int DW       = 16,
   parameter int GUARD    = 5,
   parameter int W        = 23,
   parameter int KF       = 16,
   parameter int ITER     = 17,
   parameter bit PIPE_MUL = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_valid,
   input  logic signed [W-1:0]  i_x,
   input  logic signed [W-1:0]  i_y,
   output logic                 o_valid,
   output logic signed [DW-1:0] o_re,
   output logic signed [DW-1:0] o_im
);
   localparam int PW = W + KF + 2;
   localparam int SH = KF + GUARD;
   localparam logic signed [PW-1:0] KEXT = PW'(twr_pkg::gain_code(ITER, KF));
   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);
   localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW - 1)) - 1);
   localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

   logic                 pr_v;
   logic signed [PW-1:0] pr_re, pr_im, q_re, q_im;

   function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
      if (v > MAXV)      return DW'(MAXV);
      else if (v < MINV) return DW'(MINV);
      else               return DW'(v);
   endfunction

   generate
      if (PIPE_MUL) begin : g_pipe
         always_ff @(posedge clk) begin
            if (!rst_n) pr_v <= 1'b0;
            else        pr_v <= i_valid;
            pr_re <= PW'(i_x) * KEXT;
            pr_im <= PW'(i_y) * KEXT;
         end
      end else begin : g_comb
         always_comb begin
            pr_v  = i_valid;
            pr_re = PW'(i_x) * KEXT;
            pr_im = PW'(i_y) * KEXT;
         end
      end
   endgenerate

   always_comb begin
      q_re = (pr_re + HALF) >>> SH;
      q_im = (pr_im + HALF) >>> SH;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_re    <= '0;
         o_im    <= '0;
      end else begin
         o_valid <= pr_v;
         o_re    <= pr_v ? clip(q_re) : '0;
         o_im    <= pr_v ? clip(q_im) : '0;
      end
   end

   // R6: clamping never flips the sign of a large product
   assert_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && $past(pr_v) && !$past(pr_re[PW-1])) |-> !o_re[DW-1]);
endmodule

// File: rtl/twiddle_rotator.sv
`timescale 1ns/1ps
module twiddle_rotator #(
   parameter int DW      = 16,
   parameter int GUARD   = 5,
   parameter int ITER    = 17,
   parameter int LOG_MIN = 11,
   parameter int COLW    = 5,
   parameter int ZW      = 22,
   parameter int KF      = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic [1:0]           size_sel,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im
);
   localparam int W = DW + GUARD + 2;   // two bits for quarter-turn swap and gain growth

   generate
      if (ZW < LOG_MIN + 4) begin : g_bad_zw
         $error("phase word too narrow for the largest transform");
      end
      if (ITER < 2 || ITER > ZW - 4) begin : g_bad_iter
         $error("iteration count outside the phase resolution");
      end
      if (COLW < 1 || COLW >= LOG_MIN) begin : g_bad_colw
         $error("column field must be narrower than the smallest transform");
      end
   endgenerate

   logic                 a_v;
   logic signed [DW-1:0] a_re, a_im;
   logic [ZW-1:0]        a_ang;

   logic                 sv [ITER+1];
   logic signed [W-1:0]  sx [ITER+1];
   logic signed [W-1:0]  sy [ITER+1];
   logic signed [ZW-1:0] sz [ITER+1];

   twr_index_gen #(.DW(DW), .LOG_MIN(LOG_MIN), .COLW(COLW), .ZW(ZW)) u_index (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .size_sel(size_sel), .in_re(in_re), .in_im(in_im),
      .o_valid(a_v), .o_re(a_re), .o_im(a_im), .o_ang(a_ang)
   );

   twr_prerot #(.DW(DW), .GUARD(GUARD), .W(W), .ZW(ZW)) u_prerot (
      .clk(clk), .rst_n(rst_n), .i_valid(a_v), .i_re(a_re), .i_im(a_im), .i_ang(a_ang),
      .o_valid(sv[0]), .o_x(sx[0]), .o_y(sy[0]), .o_z(sz[0])
   );

   generate
      for (genvar i = 0; i < ITER; i++) begin : g_stage
         localparam int AT = twr_pkg::atan_code(i, ZW);
         twr_micro_stage #(.W(W), .ZW(ZW), .IDX(i), .ATAN(AT)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .i_valid(sv[i]), .i_x(sx[i]), .i_y(sy[i]), .i_z(sz[i]),
            .o_valid(sv[i+1]), .o_x(sx[i+1]), .o_y(sy[i+1]), .o_z(sz[i+1])
         );
      end
   endgenerate

   twr_gain #(.DW(DW), .GUARD(GUARD), .W(W), .KF(KF), .ITER(ITER), .PIPE_MUL(1'b1)) u_gain (
      .clk(clk), .rst_n(rst_n), .i_valid(sv[ITER]), .i_x(sx[ITER]), .i_y(sy[ITER]),
      .o_valid(out_valid), .o_re(out_re), .o_im(out_im)
   );

   // R7: reset clears the output port on the following cycle
   assert_reset_quiet_R7: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_re == '0 && out_im == '0));
endmodule

// File: tb/twiddle_rotator_bench.sv
`timescale 1ns/1ps
module twiddle_rotator_bench;
   localparam int  LAT  = 21;
   localparam int  TOL  = 4;
   localparam int  QD   = 64;
   localparam real TPI  = 6.283185307179586;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sof = 1'b0;
   logic [1:0]  size_sel = 2'd0;
   logic signed [15:0] in_re = '0, in_im = '0;
   logic        out_valid;
   logic signed [15:0] out_re, out_im;

   always #2.5 clk = ~clk;

   twiddle_rotator u_twiddle_rotator (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .size_sel(size_sel), .in_re(in_re), .in_im(in_im),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
   );

   int    n_chk = 0, n_fail = 0, cyc = 0;
   int    q_re [QD], q_im [QD], q_cyc [QD];
   string q_tag [QD];
   int    wr = 0, rd = 0;
   int    m_idx = 0, m_logn = 11;
   int    seed = 32'h1234567;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int rnd_sat(input real v);
      int r;
      if (v >= 0.0) r = $rtoi(v + 0.5);
      else          r = -$rtoi(-v + 0.5);
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   function automatic int logn_req(input logic [1:0] code);
      return (code == 2'd0) ? 11 : (code == 2'd1) ? 12 : 13;   // R4
   endfunction

   function automatic int iabs(input int v);
      return v < 0 ? -v : v;
   endfunction

   function automatic int next_val();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 8) % 20000;
   endfunction

   // drive one sample and log its expected result (R1, R2, R3 model)
   task automatic send(input int re, input int im, input bit sof, input string tag);
      int  nn, n, k, ph;
      real th, er, ei;
      string t;
      @(negedge clk);
      in_valid = 1'b1; in_sof = sof;
      in_re = 16'(re); in_im = 16'(im);
      if (sof) m_idx = 0;
      m_logn = logn_req(size_sel);
      nn = 1 << m_logn;
      n  = m_idx >> 5;
      k  = m_idx & 31;
      ph = (n * k) % nn;
      th = TPI * ph / nn;
      er = re * $cos(th) + im * $sin(th);
      ei = im * $cos(th) - re * $sin(th);
      t  = tag;
      if (tag == "R1" && ph >= nn / 4 && ph < 3 * nn / 4) t = "R8";
      q_re[wr % QD] = rnd_sat(er);
      q_im[wr % QD] = rnd_sat(ei);
      q_cyc[wr % QD] = cyc;
      q_tag[wr % QD] = t;
      wr++;
      m_idx = (m_idx == nn - 1) ? 0 : m_idx + 1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_sof = 1'b0;
      end
   endtask

   // output monitor: value and 21-cycle distance (R1, R5, R6, R8)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (rd == wr) check(1'b0, "R5", "unexpected output", 1, 0);
         else begin
            check(iabs(int'(out_re) - q_re[rd % QD]) <= TOL, q_tag[rd % QD], "re",
                  int'(out_re), q_re[rd % QD]);
            check(iabs(int'(out_im) - q_im[rd % QD]) <= TOL, q_tag[rd % QD], "im",
                  int'(out_im), q_im[rd % QD]);
            check(cyc - q_cyc[rd % QD] == LAT, "R5", "latency", cyc - q_cyc[rd % QD], LAT);
            rd++;
         end
      end
   end

   task automatic t_reset();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(!out_valid && out_re == 0 && out_im == 0, "R7", "reset outputs",
               int'(out_valid) + iabs(int'(out_re)) + iabs(int'(out_im)), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      m_idx = 0;
   endtask

   task automatic t_frame_small();
      size_sel = 2'd0;
      for (int i = 0; i < 2048; i++) send(next_val(), next_val(), i == 0, "R1");
      for (int i = 0; i < 40; i++) send(next_val(), next_val(), 1'b0, "R2");   // wrap
      idle(LAT + 2);
   endtask

   task automatic t_sizes();
      size_sel = 2'd1;
      for (int i = 0; i < 4106; i++) send(next_val(), next_val(), i == 0, "R4");
      size_sel = 2'd2;
      for (int i = 0; i < 2500; i++) send(next_val(), next_val(), i == 0, "R4");
      size_sel = 2'd3;
      for (int i = 0; i < 1200; i++) send(next_val(), next_val(), i == 0, "R4");
      idle(LAT + 2);
   endtask

   task automatic t_sof_mid();
      size_sel = 2'd0;
      for (int i = 0; i < 700; i++) send(next_val(), next_val(), i == 0, "R3");
      for (int i = 0; i < 200; i++) send(next_val(), next_val(), i == 0, "R3");
      idle(LAT + 2);
   endtask

   task automatic t_gaps();
      size_sel = 2'd0;
      for (int i = 0; i < 700; i++) begin
         send(next_val(), next_val(), i == 0, "R5");
         if (i % 3 == 1) idle(i % 5 + 1);
      end
      idle(LAT + 2);
   endtask

   task automatic t_saturate();
      size_sel = 2'd0;
      for (int i = 0; i < 528; i++) send(1000, -500, i == 0, "R6");
      send(32767, 32767, 1'b0, "R6");      // angle near an eighth turn
      send(-32768, -32768, 1'b0, "R6");
      send(32767, -32768, 1'b0, "R6");
      send(-32768, 32767, 1'b0, "R6");
      idle(LAT + 4);
   endtask

   initial begin
      t_reset();
      t_frame_small();
      t_sizes();
      t_sof_mid();
      t_gaps();
      t_saturate();
      check(rd == wr, "R5", "results outstanding", wr - rd, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R5", "watchdog expired", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule